// File: doc/BRIEF.md
# Addressed Serial Loader for a Multi-Channel DAC

This block is the digital front end of a multi-channel digital-to-analog converter. An external controller drives three wires: a serial clock, a data line and an active-low select/load strobe. While the select line is low, every rising serial-clock edge shifts one data bit into a 16-bit frame register. When the select line goes high again, the frame is decoded. Its leading 4 bits name a channel, or all channels at once. The code field that follows is written into the matching parallel output register or registers. The analog converters read those registers directly.

The most significant stage of the frame register is driven out on a serial output pin. Several devices can therefore share the clock and the select line, with each serial output feeding the next device's data input. The controller clocks 16 bits per device and then raises the select line once, which updates every device in the chain on the same edge. The design runs entirely on a system clock. The three interface wires are resynchronized, and their edges are found from the resynchronized values. A one-cycle strobe reports each register write together with the channel it touched.

Top module: `dac_serial_loader`

## Requirements
- R1: After reset every channel register holds code zero, the serial output is 0 and the update strobe is low.
- R2: While the select line is low, each rising serial-clock edge shifts the data line into bit 0 of the frame register and moves every stage up by one. The serial output shows bit 15, so a bit presented on the data line appears there after 16 rising edges.
- R3: The frame fields are fixed by shift order. Bits 15..12 hold the address, and the address is shifted first. The next CODE_W bits hold the code, most significant bit first. The remaining 12-CODE_W low bits are padding, and their values never affect any output register.
- R4: On a rising edge of the select line, an address k in 1..NUM_CH writes the code into channel k-1 and leaves every other channel unchanged.
- R5: Address 15 writes the code into every channel on the same load.
- R6: Address 0 and addresses NUM_CH+1 to 14 change no channel and raise no update strobe.
- R7: Serial-clock edges while the select line is high do not alter the frame register.
- R8: If the select line rises after a count of clock edges that is not a multiple of 16, the load uses the frame register as it stands, which holds the last 16 bits shifted in.
- R9: With one device's serial output wired to the next device's data input, 32 bits clocked during one low period of the select line followed by a single rising edge update both devices. The device farther down the chain takes the first 16 bits.
- R10: Each load that writes registers raises the update strobe for exactly one system clock. For a single channel the index output is k-1 and the broadcast flag is 0. For address 15 the broadcast flag is 1 and the index output is 0.
- R11: With CODE_W set to 10, the code occupies bits 11..2 and the 2 low bits are padding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the controller |
| cs_ld_i | input | 1 | Active-low select; its rising edge loads the frame |
| din_i | input | 1 | Serial data in |
| dout_o | output | 1 | Serial data out, frame bit 15, for chaining |
| codes_o | output | NUM_CH*CODE_W | Channel code registers, channel c at bits c*CODE_W upward |
| upd_stb_o | output | 1 | One-cycle pulse when a load writes registers |
| upd_idx_o | output | IDX_W | Written channel index for a single-channel write |
| upd_all_o | output | 1 | Set with the strobe when all channels were written |

## Verification
The bench builds two instances and chains them. The first uses 8-bit codes and 8 channels. The second uses 10-bit codes and 4 channels and takes its data from the first instance's serial output. With this pairing the bench exercises the 2-padding-bit frame layout and a genuine two-device chain loaded by one select edge. It also reaches addresses 5 to 8, which are real channels for the first device and no-ops for the second. A running model of both frame registers gives the expected serial output after every edge, and also covers partial frames and edges that arrive while the select line is high.

// File: rtl/dac_loader_pkg.sv
package dac_loader_pkg;
    // Fixed frame geometry; the address sits in the first-shifted bits.
    localparam int FRAME_W  = 16;
    localparam int ADDR_W   = 4;
    localparam int ADDR_LSB = FRAME_W - ADDR_W;
    localparam logic [ADDR_W-1:0] ADDR_ALL = 4'hF;
    // Bit positions of the resynchronized interface bundle.
    localparam int SIG_DIN = 0;
    localparam int SIG_SCK = 1;
    localparam int SIG_CS  = 2;
    localparam int SIG_N   = 3;
endpackage

// File: rtl/dac_ld_sync.sv
module dac_ld_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] pipe;
    } sync_t;

    sync_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        state_d.pipe[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            state_d.pipe[s] = state_q.pipe[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q.pipe <= {STAGES{RST_VAL}};
        end else begin
            state_q <= state_d;
        end
    end

    assign sync_o = state_q.pipe[STAGES-1];
endmodule

// File: rtl/dac_ld_front.sv
module dac_ld_front
    import dac_loader_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               sck_s_i,
    input  logic               cs_s_i,
    input  logic               din_s_i,
    output logic               shift_fire_o,
    output logic               load_fire_o,
    output logic [FRAME_W-1:0] word_o,
    output logic               dout_o
);
    typedef struct packed {
        logic               sck_prev;
        logic               cs_prev;
        logic [FRAME_W-1:0] sr;
    } front_t;

    localparam front_t FRONT_RST = '{sck_prev: 1'b0, cs_prev: 1'b1, sr: '0};

    front_t state_d, state_q;
    logic   sck_rise;
    logic   cs_rise;

    always_comb begin
        sck_rise = sck_s_i & ~state_q.sck_prev;
        cs_rise  = cs_s_i & ~state_q.cs_prev;

        state_d          = state_q;
        state_d.sck_prev = sck_s_i;
        state_d.cs_prev  = cs_s_i;
        // Shift only while selected; edges with select high are dropped.
        if (sck_rise && !cs_s_i) begin
            state_d.sr = {state_q.sr[FRAME_W-2:0], din_s_i};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= FRONT_RST;
        end else begin
            state_q <= state_d;
        end
    end

    assign shift_fire_o = sck_rise & ~cs_s_i;
    assign load_fire_o  = cs_rise;
    assign word_o       = state_q.sr;
    assign dout_o       = state_q.sr[FRAME_W-1];
endmodule

// File: rtl/dac_ld_bank.sv
module dac_ld_bank
    import dac_loader_pkg::*;
#(
    parameter  int CODE_W = 8,
    parameter  int NUM_CH = 8,
    localparam int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     load_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [CODE_W-1:0]        code_i,
    output logic [NUM_CH*CODE_W-1:0] codes_o,
    output logic                     upd_stb_o,
    output logic [IDX_W-1:0]         upd_idx_o,
    output logic                     upd_all_o
);
    typedef struct packed {
        logic [NUM_CH-1:0][CODE_W-1:0] codes;
        logic                          stb;
        logic [IDX_W-1:0]              idx;
        logic                          all;
    } bank_t;

    bank_t             state_d, state_q;
    logic              is_all;
    logic [NUM_CH-1:0] wr_sel;

    assign is_all = (addr_i == ADDR_ALL);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
        assign wr_sel[c] = load_i && (is_all || (addr_i == ADDR_W'(c + 1)));
    end

    always_comb begin
        state_d     = state_q;
        state_d.stb = 1'b0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (wr_sel[c]) begin
                state_d.codes[c] = code_i;
            end
        end
        if (|wr_sel) begin
            state_d.stb = 1'b1;
            state_d.all = is_all;
            state_d.idx = is_all ? '0 : IDX_W'(addr_i - ADDR_W'(1));
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign codes_o   = state_q.codes;
    assign upd_stb_o = state_q.stb;
    assign upd_idx_o = state_q.idx;
    assign upd_all_o = state_q.all;
endmodule

// File: rtl/dac_serial_loader.sv
module dac_serial_loader
    import dac_loader_pkg::*;
#(
    parameter  int CODE_W      = 8,
    parameter  int NUM_CH      = 8,
    parameter  int SYNC_STAGES = 2,
    localparam int IDX_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     sck_i,
    input  logic                     cs_ld_i,
    input  logic                     din_i,
    output logic                     dout_o,
    output logic [NUM_CH*CODE_W-1:0] codes_o,
    output logic                     upd_stb_o,
    output logic [IDX_W-1:0]         upd_idx_o,
    output logic                     upd_all_o
);
    localparam int CODE_MSB = ADDR_LSB - 1;
    localparam logic [SIG_N-1:0] SYNC_RST = SIG_N'(1) << SIG_CS;

    logic [SIG_N-1:0]   pins_raw;
    logic [SIG_N-1:0]   pins_s;
    logic               shift_fire;
    logic               load_fire;
    logic [FRAME_W-1:0] frame_word;

    always_comb begin
        pins_raw          = '0;
        pins_raw[SIG_DIN] = din_i;
        pins_raw[SIG_SCK] = sck_i;
        pins_raw[SIG_CS]  = cs_ld_i;
    end

    dac_ld_sync #(
        .WIDTH   (SIG_N),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) sync_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (pins_raw),
        .sync_o  (pins_s)
    );

    dac_ld_front front_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .sck_s_i      (pins_s[SIG_SCK]),
        .cs_s_i       (pins_s[SIG_CS]),
        .din_s_i      (pins_s[SIG_DIN]),
        .shift_fire_o (shift_fire),
        .load_fire_o  (load_fire),
        .word_o       (frame_word),
        .dout_o       (dout_o)
    );

    dac_ld_bank #(
        .CODE_W (CODE_W),
        .NUM_CH (NUM_CH)
    ) bank_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (load_fire),
        .addr_i    (frame_word[FRAME_W-1:ADDR_LSB]),
        .code_i    (frame_word[CODE_MSB -: CODE_W]),
        .codes_o   (codes_o),
        .upd_stb_o (upd_stb_o),
        .upd_idx_o (upd_idx_o),
        .upd_all_o (upd_all_o)
    );
endmodule

// File: rtl/dac_serial_loader_chk.sv
module dac_serial_loader_chk
    import dac_loader_pkg::*;
#(
    parameter int NUM_CH  = 8,
    parameter int CODES_W = 64,
    parameter int IDX_W   = 3
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               shift_fire,
    input logic               load_fire,
    input logic [FRAME_W-1:0] frame_word,
    input logic               dout_o,
    input logic [CODES_W-1:0] codes_o,
    input logic               upd_stb_o,
    input logic [IDX_W-1:0]   upd_idx_o,
    input logic               upd_all_o
);
    // R2: after a shift the serial output carries the stage below the old top
    p_dout_shift_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shift_fire |=> (dout_o == $past(frame_word[FRAME_W-2])));

    // R7: with no accepted edge the frame register holds
    p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !shift_fire |=> $stable(frame_word));

    // R4: channel registers move only together with the strobe
    p_code_change_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(codes_o) |-> upd_stb_o);

    // R10: the strobe lasts one cycle
    p_strobe_once_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        upd_stb_o |=> !upd_stb_o);

    // R10: a strobe is always caused by a load edge
    p_strobe_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        upd_stb_o |-> $past(load_fire));

    // R6: a single-channel strobe never names a channel outside the bank
    p_idx_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (upd_stb_o && !upd_all_o) |-> (int'(upd_idx_o) < NUM_CH));
endmodule

bind dac_serial_loader dac_serial_loader_chk #(
    .NUM_CH  (NUM_CH),
    .CODES_W (NUM_CH * CODE_W),
    .IDX_W   (IDX_W)
) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_fire (shift_fire),
    .load_fire  (load_fire),
    .frame_word (frame_word),
    .dout_o     (dout_o),
    .codes_o    (codes_o),
    .upd_stb_o  (upd_stb_o),
    .upd_idx_o  (upd_idx_o),
    .upd_all_o  (upd_all_o)
);

// File: tb/dac_serial_loader_tb_top.sv
module dac_serial_loader_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCK   = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sck, cs, din;
    logic        dout1, dout2;
    logic [63:0] codes1;
    logic [39:0] codes2;
    logic        stb1, all1, stb2, all2;
    logic [2:0]  idx1;
    logic [1:0]  idx2;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    bit dout_watch = 0;

    // Bench-side expectation of both frame registers and all channel codes
    logic [15:0] m_sr1 = '0, m_sr2 = '0;
    logic [7:0]  m_c1 [8];
    logic [9:0]  m_c2 [4];
    int          exp_stb = 0;
    logic [2:0]  exp_idx = '0;
    logic        exp_all = 1'b0;
    int          stb_cnt = 0;
    logic [2:0]  last_idx = '0;
    logic        last_all = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_serial_loader #(.CODE_W(8), .NUM_CH(8)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ld_i(cs), .din_i(din),
        .dout_o(dout1), .codes_o(codes1), .upd_stb_o(stb1),
        .upd_idx_o(idx1), .upd_all_o(all1));

    dac_serial_loader #(.CODE_W(10), .NUM_CH(4)) dut2_i (
        .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ld_i(cs), .din_i(dout1),
        .dout_o(dout2), .codes_o(codes2), .upd_stb_o(stb2),
        .upd_idx_o(idx2), .upd_all_o(all2));

    always @(negedge clk) begin
        if (rst_n && stb1) begin
            stb_cnt  <= stb_cnt + 1;
            last_idx <= idx1;
            last_all <= all1;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clock_bit(input logic b);
        din = b;
        tick(HALF_SCK);
        sck = 1'b1;
        m_sr2 = {m_sr2[14:0], m_sr1[15]};
        m_sr1 = {m_sr1[14:0], b};
        tick(HALF_SCK);
        sck = 1'b0;
        if (dout_watch) begin
            check(dout1 == m_sr1[15], "R2", "dout first device", 64'(dout1), 64'(m_sr1[15]));
            check(dout2 == m_sr2[15], "R2", "dout second device", 64'(dout2), 64'(m_sr2[15]));
        end
    endtask

    task automatic send_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) clock_bit(w[i]);
    endtask

    task automatic cs_low();
        cs = 1'b0;
        tick(HALF_SCK);
    endtask

    task automatic model_load();
        logic [3:0] a1, a2;
        a1 = m_sr1[15:12];
        a2 = m_sr2[15:12];
        if (a1 >= 1 && a1 <= 8) begin
            m_c1[a1-1] = m_sr1[11:4];
            exp_stb++; exp_idx = 3'(a1 - 1); exp_all = 1'b0;
        end else if (a1 == 4'hF) begin
            for (int c = 0; c < 8; c++) m_c1[c] = m_sr1[11:4];
            exp_stb++; exp_idx = 3'd0; exp_all = 1'b1;
        end
        if (a2 >= 1 && a2 <= 4) m_c2[a2-1] = m_sr2[11:2];
        else if (a2 == 4'hF) for (int c = 0; c < 4; c++) m_c2[c] = m_sr2[11:2];
    endtask

    task automatic cs_load();
        tick(HALF_SCK);
        cs = 1'b1;
        model_load();
        tick(2 * HALF_SCK);
    endtask

    task automatic check_state(input string req);
        logic [63:0] e1;
        logic [39:0] e2;
        for (int c = 0; c < 8; c++) e1[c*8 +: 8] = m_c1[c];
        for (int c = 0; c < 4; c++) e2[c*10 +: 10] = m_c2[c];
        check(codes1 === e1, req, "codes first device", codes1, e1);
        check(codes2 === e2, req, "codes second device", 64'(codes2), 64'(e2));
        check(stb_cnt == exp_stb, req, "strobe count", 64'(stb_cnt), 64'(exp_stb));
        if (exp_stb > 0)
            check({last_all, last_idx} == {exp_all, exp_idx}, req, "strobe all/index",
                  64'({last_all, last_idx}), 64'({exp_all, exp_idx}));
    endtask

    task automatic frame(input logic [15:0] w);
        cs_low();
        send_word(w);
        cs_load();
    endtask

    // R1
    task automatic t_reset();
        check(codes1 == '0, "R1", "codes first device", codes1, 64'd0);
        check(codes2 == '0, "R1", "codes second device", 64'(codes2), 64'd0);
        check(dout1 == 1'b0, "R1", "dout", 64'(dout1), 64'd0);
        check(stb1 == 1'b0, "R1", "strobe", 64'(stb1), 64'd0);
    endtask

    // R3 R4 R10: single-channel writes with padding bits set
    task automatic t_single();
        frame({4'd3, 8'hA5, 4'hF});
        check_state("R4");
        frame({4'd8, 8'h3C, 4'h9});
        check_state("R3");
        frame({4'd1, 8'h81, 4'h6});
        check_state("R10");
    endtask

    // R5 R10
    task automatic t_broadcast();
        frame({4'hF, 8'h5E, 4'h0});
        check_state("R5");
        frame({4'd2, 8'h11, 4'h0});
        check_state("R4");
    endtask

    // R6: no-op addresses
    task automatic t_noop();
        frame({4'd0, 8'hFF, 4'hF});
        check_state("R6");
        frame({4'd9, 8'h77, 4'h0});
        check_state("R6");
        frame({4'd14, 8'h42, 4'h3});
        check_state("R6");
    endtask

    // R2: serial output tracks the frame register edge by edge
    task automatic t_dout();
        dout_watch = 1;
        cs_low();
        send_word(16'hC3A5);
        send_word({4'd6, 8'h99, 4'h0});
        cs_load();
        dout_watch = 0;
        check_state("R2");
    endtask

    // R7: edges with select high are dropped; an empty select reloads the word
    task automatic t_ignore();
        frame({4'd4, 8'hD2, 4'h0});
        for (int i = 0; i < 10; i++) begin
            din = 1'b1;
            tick(HALF_SCK);
            sck = 1'b1;
            tick(HALF_SCK);
            sck = 1'b0;
        end
        check(dout1 == m_sr1[15], "R7", "dout while deselected", 64'(dout1), 64'(m_sr1[15]));
        cs_low();
        cs_load();
        check_state("R7");
    endtask

    // R8: partial frames
    task automatic t_partial();
        cs_low();
        send_word({4'd5, 8'h12, 4'h3});
        for (int i = 0; i < 4; i++) clock_bit(1'(i == 1 || i == 3));
        cs_load();
        check_state("R8");
        cs_low();
        for (int i = 0; i < 12; i++) clock_bit(1'(i % 3 == 0));
        cs_load();
        check_state("R8");
    endtask

    // R9 R11: two chained devices, one load edge
    task automatic t_chain();
        cs_low();
        send_word({4'd2, 10'h2B7, 2'b11});
        send_word({4'd7, 8'hE4, 4'hA});
        cs_load();
        check_state("R9");
        cs_low();
        send_word({4'hF, 10'h1C9, 2'b01});
        send_word({4'd0, 8'h00, 4'h0});
        cs_load();
        check_state("R11");
        cs_low();
        send_word({4'd6, 10'h3FF, 2'b00});
        send_word({4'd6, 8'h6B, 4'h0});
        cs_load();
        check_state("R9");
    endtask

    initial begin
        for (int c = 0; c < 8; c++) m_c1[c] = '0;
        for (int c = 0; c < 4; c++) m_c2[c] = '0;
        rst_n = 1'b0;
        cs    = 1'b1;
        sck   = 1'b0;
        din   = 1'b0;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_single();
        t_broadcast();
        t_noop();
        t_dout();
        t_ignore();
        t_partial();
        t_chain();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule